// File: doc/BRIEF.md
# Conversion-Cycle Serial Output Port

This block models the digital output side of a sampling converter. It runs a fixed cycle. A power-on reset interval comes first. A conversion follows, then a sleep phase while the host keeps the select line high. Last comes a serial readout phase, after which the cycle repeats. The conversion itself is a stub: a counter that runs for a parameterized number of system clocks. When it ends, it captures a 28-bit sample value and two status flags from the block's inputs. Those are the 24 main bits, the 4 bits below them, a sign flag and an out-of-range flag.

The host drives an active-low select and a serial clock. Both are brought into the system clock domain through two-flop synchronizers, and their edges are found there. While select is low, the serial data line is driven; otherwise it floats. During a conversion the line reads high as a busy flag. Once a result is ready, the line presents a 32-bit frame. The frame advances on every falling serial-clock edge, so the host can sample on rising edges. A new conversion starts either when the host clocks out the whole frame or when it releases select part way through.

Top module: `sigma_port`

## Requirements
- R1: While `rst_i` is high, `state_o` is 2'b00 (power-on) and `sdo_oe_o` is low. After reset is released, the block stays in power-on for `POR_CYCLES` clocks and then enters conversion (2'b01).
- R2: A conversion captures `smp_value_i`, `smp_sign_i` and `smp_exr_i` at its end. If select is high at that moment, the block enters sleep (2'b10) and stays there as long as select stays high.
- R3: While select is high, `sdo_o` is high impedance and `sdo_oe_o` is low. Serial clock pulses then change nothing. Input changes during sleep do not alter the held frame.
- R4: With select low during a conversion, `sdo_o` is driven high. It falls to low when the conversion completes, and the block then enters readout (2'b11) without a sleep phase.
- R5: The frame is 32 bits, sent bit 31 first. Bit 31 is the busy flag (0 once complete). Bit 30 is always 0. Bit 29 is the captured sign and bit 28 the captured range flag. Bits 27..4 are the 24 main bits, most significant first, and bits 3..0 are the 4 low bits.
- R6: Bit 31 is on `sdo_o` before the first serial-clock rise. Each later bit appears after a falling edge (bit 30 after the first fall, bit 0 after the 31st). Inputs reach the output three system clocks after a pin change.
- R7: On the 32nd falling edge, `sdo_o` goes high and a new conversion starts (state 2'b01).
- R8: Raising select before the frame is finished ends readout and starts a new conversion. The next frame carries a freshly captured sample.
- R9: When select rises in the same synchronized cycle as the 32nd falling edge, exactly one new conversion starts and the line floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| sel_n_i | input | 1 | Active-low select from the host (asynchronous) |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| smp_value_i | input | 28 | Stubbed conversion value: 24 main bits then 4 low bits |
| smp_sign_i | input | 1 | Stubbed sign flag |
| smp_exr_i | input | 1 | Stubbed out-of-range flag |
| sdo_o | output | 1 | Serial data, high impedance while deselected |
| sdo_oe_o | output | 1 | Drive enable of `sdo_o` |
| state_o | output | 2 | 00 power-on, 01 converting, 10 sleep, 11 readout |

## Verification
Two events can land in the same system-clock cycle and both end a readout: the 32nd falling edge of the serial clock and the release of select. The bench provokes the overlap by dropping the serial clock and raising select at the same instant, so both reach the synchronizers together. It then checks three things. The state must show a conversion, the data line must float, and the state must stay converting through most of the conversion time. A normal, correct frame must follow, which shows that exactly one restart took place. A second overlap is also exercised: select is held low while a conversion completes, and the bench checks that the busy level falls and readout begins on its own.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int FRAME_W = 32;
    localparam int MAIN_W  = 24;
    localparam int SUB_W   = 4;
    localparam int RES_W   = MAIN_W + SUB_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        ST_POR   = 2'b00,
        ST_CONV  = 2'b01,
        ST_SLEEP = 2'b10,
        ST_XFER  = 2'b11
    } port_state_e;

    typedef struct packed {
        logic             sign;
        logic             exr;
        logic [RES_W-1:0] value;
    } result_t;

    typedef struct packed {
        logic             busy;
        logic             pad;
        logic             sign;
        logic             exr;
        logic [RES_W-1:0] value;
    } frame_t;

    function automatic frame_t make_frame(result_t r);
        frame_t f;
        f.busy  = 1'b0;
        f.pad   = 1'b0;
        f.sign  = r.sign;
        f.exr   = r.exr;
        f.value = r.value;
        return f;
    endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/sp_conv_engine.sv
module sp_conv_engine
    import sp_pkg::*;
#(
    parameter int CONV_CYCLES = 64
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    start_i,
    input  result_t sample_i,
    output logic    done_o,
    output result_t result_o
);
    localparam int TW = $clog2(CONV_CYCLES + 1);

    logic          busy_q;
    logic [TW-1:0] tick_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q   <= 1'b0;
            tick_q   <= '0;
            done_o   <= 1'b0;
            result_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                busy_q <= 1'b1;
                tick_q <= '0;
            end else if (busy_q) begin
                if (tick_q == TW'(CONV_CYCLES - 1)) begin
                    busy_q   <= 1'b0;
                    done_o   <= 1'b1;
                    result_o <= sample_i;
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sp_frame_shifter.sv
module sp_frame_shifter
    import sp_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   load_i,
    input  frame_t frame_i,
    input  logic   shift_i,
    output logic [FRAME_W-1:0] frame_q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            frame_q_o <= '0;
        end else if (load_i) begin
            frame_q_o <= frame_i;
        end else if (shift_i) begin
            frame_q_o <= {frame_q_o[FRAME_W-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
    import sp_pkg::*;
#(
    parameter int POR_CYCLES = 100000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sel_n_s_i,
    input  logic              sclk_fall_i,
    input  logic              done_i,
    output port_state_e       state_o,
    output logic              start_o,
    output logic              shift_o,
    output logic [CNT_W-1:0]  bit_cnt_o
);
    localparam int PW = $clog2(POR_CYCLES + 1);

    logic [PW-1:0] por_q;
    logic          last_fall;

    assign shift_o   = (state_o == ST_XFER) && !sel_n_s_i && sclk_fall_i;
    assign last_fall = shift_o && (bit_cnt_o == CNT_W'(FRAME_W - 1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_o   <= ST_POR;
            por_q     <= '0;
            bit_cnt_o <= '0;
            start_o   <= 1'b0;
        end else begin
            start_o <= 1'b0;
            unique case (state_o)
                ST_POR: begin
                    if (por_q == PW'(POR_CYCLES - 1)) begin
                        state_o <= ST_CONV;
                        start_o <= 1'b1;
                    end else begin
                        por_q <= por_q + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (done_i) begin
                        bit_cnt_o <= '0;
                        state_o   <= sel_n_s_i ? ST_SLEEP : ST_XFER;
                    end
                end
                ST_SLEEP: begin
                    if (!sel_n_s_i) state_o <= ST_XFER;
                end
                ST_XFER: begin
                    if (sel_n_s_i || last_fall) begin
                        state_o   <= ST_CONV;
                        start_o   <= 1'b1;
                        bit_cnt_o <= '0;
                    end else if (shift_o) begin
                        bit_cnt_o <= bit_cnt_o + 1'b1;
                    end
                end
                default: state_o <= ST_POR;
            endcase
        end
    end
endmodule

// File: rtl/sigma_port.sv
module sigma_port
    import sp_pkg::*;
#(
    parameter int POR_CYCLES  = 100000,
    parameter int CONV_CYCLES = 64
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sel_n_i,
    input  logic             sclk_i,
    input  logic [RES_W-1:0] smp_value_i,
    input  logic             smp_sign_i,
    input  logic             smp_exr_i,
    output logic             sdo_o,
    output logic             sdo_oe_o,
    output logic [1:0]       state_o
);
    logic               sel_n_s;
    logic               sclk_s;
    logic               sclk_prev_q;
    logic               sclk_fall;
    logic               start_w;
    logic               shift_w;
    logic               done_w;
    logic [CNT_W-1:0]   bit_cnt_w;
    port_state_e        state_w;
    result_t            sample_w;
    result_t            result_w;
    logic [FRAME_W-1:0] frame_q;
    logic               sdo_bit;

    sp_sync #(.W(1), .RST_VAL(1'b1)) u_sync_sel (
        .clk_i(clk_i), .rst_i(rst_i), .d_i(sel_n_i), .q_o(sel_n_s)
    );

    sp_sync #(.W(1), .RST_VAL(1'b0)) u_sync_sclk (
        .clk_i(clk_i), .rst_i(rst_i), .d_i(sclk_i), .q_o(sclk_s)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) sclk_prev_q <= 1'b0;
        else       sclk_prev_q <= sclk_s;
    end

    assign sclk_fall = sclk_prev_q && !sclk_s;

    sp_ctrl #(.POR_CYCLES(POR_CYCLES)) u_ctrl (
        .clk_i(clk_i), .rst_i(rst_i), .sel_n_s_i(sel_n_s),
        .sclk_fall_i(sclk_fall), .done_i(done_w), .state_o(state_w),
        .start_o(start_w), .shift_o(shift_w), .bit_cnt_o(bit_cnt_w)
    );

    assign sample_w.sign  = smp_sign_i;
    assign sample_w.exr   = smp_exr_i;
    assign sample_w.value = smp_value_i;

    sp_conv_engine #(.CONV_CYCLES(CONV_CYCLES)) u_engine (
        .clk_i(clk_i), .rst_i(rst_i), .start_i(start_w),
        .sample_i(sample_w), .done_o(done_w), .result_o(result_w)
    );

    sp_frame_shifter u_shift (
        .clk_i(clk_i), .rst_i(rst_i), .load_i(done_w),
        .frame_i(make_frame(result_w)), .shift_i(shift_w),
        .frame_q_o(frame_q)
    );

    assign sdo_bit  = ((state_w == ST_CONV) || (state_w == ST_POR)) ? 1'b1
                                                                    : frame_q[FRAME_W-1];
    assign sdo_oe_o = !sel_n_s;
    assign sdo_o    = sdo_oe_o ? sdo_bit : 1'bz;
    assign state_o  = state_w;
endmodule

// File: rtl/sp_port_chk.sv
module sp_port_chk
    import sp_pkg::*;
(
    input logic               clk_i,
    input logic               rst_i,
    input logic               sel_n_i,
    input logic               sdo_oe_o,
    input logic               sdo_bit,
    input port_state_e        state_w,
    input logic               shift_w,
    input logic               done_w,
    input logic [CNT_W-1:0]   bit_cnt_w,
    input logic [FRAME_W-1:0] frame_q
);
    // R1
    por_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> state_w == ST_POR);

    // R3
    hiz_deselect_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_n_i && $past(sel_n_i) && $past(sel_n_i, 2)) |-> !sdo_oe_o);

    // R3
    sleep_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_w == ST_SLEEP) |=> $stable(frame_q));

    // R4
    busy_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_w == ST_CONV && sdo_oe_o) |-> sdo_bit);

    // R5
    pad_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_w |=> !frame_q[FRAME_W-2]);

    // R7
    frame_end_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (shift_w && bit_cnt_w == CNT_W'(FRAME_W - 1)) |=> state_w == ST_CONV);

    // R2
    sleep_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_w == ST_SLEEP) |-> ($past(state_w) == ST_SLEEP || $past(state_w) == ST_CONV));
endmodule

bind sigma_port sp_port_chk u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .sel_n_i(sel_n_i), .sdo_oe_o(sdo_oe_o),
    .sdo_bit(sdo_bit), .state_w(state_w), .shift_w(shift_w), .done_w(done_w),
    .bit_cnt_w(bit_cnt_w), .frame_q(frame_q)
);

// File: tb/tb_sigma_port.sv
module tb_sigma_port;
    localparam int POR_N  = 40;
    localparam int CONV_N = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_n;
    logic        sclk;
    logic [27:0] value;
    logic        sign;
    logic        exr;
    logic        sdo;
    logic        sdo_oe;
    logic [1:0]  state;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    sigma_port #(.POR_CYCLES(POR_N), .CONV_CYCLES(CONV_N)) dut (
        .clk_i(clk), .rst_i(rst), .sel_n_i(sel_n), .sclk_i(sclk),
        .smp_value_i(value), .smp_sign_i(sign), .smp_exr_i(exr),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .state_o(state)
    );

    // {sign, exr, value}
    localparam logic [29:0] VEC [5] = '{
        {1'b1, 1'b0, 28'h8A5C3E7},
        {1'b1, 1'b1, 28'hFFFFFFF},
        {1'b0, 1'b0, 28'h0000000},
        {1'b0, 1'b1, 28'h5A5A5A5},
        {1'b1, 1'b0, 28'h0000001}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_state(input logic [1:0] s, input int limit);
        for (int i = 0; i < limit && state != s; i++) @(negedge clk);
    endtask

    task automatic set_in(input logic [29:0] v);
        {sign, exr, value} = v;
    endtask

    // Lowers select, samples bit 31, then gives nfall falling edges and
    // samples one bit after each of the first 31.
    task automatic read_bits(input int nfall, output logic [31:0] got);
        got = '0;
        sel_n = 1'b0;
        clocks(6);
        got[31] = sdo;
        for (int i = 1; i <= nfall; i++) begin
            sclk = 1'b1;
            clocks(4);
            sclk = 1'b0;
            clocks(6);
            if (i < 32) got[31-i] = sdo;
        end
    endtask

    initial begin
        clocks(150000);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        logic [31:0] exp;
        rst = 1'b1; sel_n = 1'b1; sclk = 1'b0;
        set_in(VEC[0]);
        clocks(4);
        // R1 reset state
        chk(state == 2'b00, "R1 reset state", 32'(state), 32'd0);
        chk(sdo_oe == 1'b0 && sdo === 1'bz, "R1 R3 line floats in reset",
            32'(sdo_oe), 32'd0);
        rst = 1'b0;
        clocks(POR_N - 4);
        chk(state == 2'b00, "R1 power-on interval held", 32'(state), 32'd0);
        wait_state(2'b01, 20);
        chk(state == 2'b01, "R1 conversion after power-on", 32'(state), 32'd1);

        // table walk: sleep, ignored clocks, held result, full frame, restart
        for (int v = 0; v < 5; v++) begin
            wait_state(2'b10, 400);
            chk(state == 2'b10, "R2 sleep after conversion", 32'(state), 32'd2);
            for (int k = 0; k < 5; k++) begin
                sclk = 1'b1; clocks(4); sclk = 1'b0; clocks(4);
            end
            chk(sdo === 1'bz && sdo_oe == 1'b0, "R3 line floats while deselected",
                32'(sdo_oe), 32'd0);
            set_in(~VEC[v]);
            clocks(3);
            exp = {2'b00, VEC[v]};
            read_bits(32, got);
            // R5 frame layout, R6 falling-edge update
            chk(got == exp, "R5 R6 frame contents", got, exp);
            chk(sdo === 1'b1, "R7 line high after last fall", 32'(sdo), 32'd1);
            chk(state == 2'b01, "R7 new conversion after frame", 32'(state), 32'd1);
            sel_n = 1'b1;
            set_in(VEC[(v + 1) % 5]);
            clocks(3);
        end

        // R4: select low through a conversion
        wait_state(2'b10, 400);
        read_bits(32, got);
        set_in(VEC[3]);
        clocks(4);
        chk(state == 2'b01 && sdo === 1'b1, "R4 busy level during conversion",
            32'(sdo), 32'd1);
        for (int i = 0; i < 400 && sdo !== 1'b0; i++) @(negedge clk);
        chk(sdo === 1'b0, "R4 busy level falls at completion", 32'(sdo), 32'd0);
        chk(state == 2'b11, "R4 readout entered without sleep", 32'(state), 32'd3);
        read_bits(32, got);
        exp = {2'b00, VEC[3]};
        chk(got == exp, "R4 frame after live completion", got, exp);
        sel_n = 1'b1;

        // R8: abort part way
        set_in(VEC[1]);
        wait_state(2'b10, 400);
        read_bits(10, got);
        exp = {2'b00, VEC[1]};
        chk(got[31:22] == exp[31:22], "R8 partial frame bits", 32'(got[31:22]),
            32'(exp[31:22]));
        sel_n = 1'b1;
        set_in(VEC[4]);
        clocks(4);
        chk(state == 2'b01, "R8 abort starts conversion", 32'(state), 32'd1);
        wait_state(2'b10, 400);
        read_bits(32, got);
        exp = {2'b00, VEC[4]};
        chk(got == exp, "R8 fresh sample after abort", got, exp);
        sel_n = 1'b1;

        // R9: select rise together with the 32nd fall
        set_in(VEC[2]);
        wait_state(2'b10, 400);
        read_bits(31, got);
        sclk = 1'b1;
        clocks(4);
        sclk = 1'b0;
        sel_n = 1'b1;
        clocks(5);
        chk(state == 2'b01 && sdo === 1'bz, "R9 single restart, line floats",
            32'(state), 32'd1);
        set_in(VEC[0]);
        clocks(CONV_N - 20);
        chk(state == 2'b01, "R9 conversion still running", 32'(state), 32'd1);
        wait_state(2'b10, 400);
        read_bits(32, got);
        exp = {2'b00, VEC[0]};
        chk(got == exp, "R9 frame after coincident end", got, exp);
        sel_n = 1'b1;
        clocks(4);

        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule